// File: doc/BRIEF.md
# Per-Source Interrupt Control Cell

This block holds the interrupt state of one interrupt source inside a peripheral I/O controller. Four flags are kept: pending, under-service, enable and error. A CPU changes them only by writing a byte whose top three bits carry a command code. The source's own event logic supplies a one-cycle event strobe, which marks the source pending. A second event that arrives while the source is still pending sets the error flag.

The cell joins its flags with a master interrupt enable and a daisy-chain enable input. From these it drives an interrupt request and a chain enable for lower-priority sources. When the CPU acknowledges an active request, the source goes under service. One cycle later the cell presents the group's interrupt vector. Depending on a "vector carries status" control, the vector can embed the current flags. With the no-vector control set, no vector is returned.

The flags can be read back at any time as a status byte. The master reset bit, decoded elsewhere and delivered as a strobe, clears the cell.

Top module: `irq_src_cell`

## Requirements
- R1: While rst_n is low, and in the cycle after a clock edge at which soft_rst_i is high, all four flags read 0, irq_o is 0 and vec_valid_o is 0. soft_rst_i takes priority over every other input.
- R2: status_o shows bit 7 = under-service, bit 6 = enable, bit 5 = pending, bit 4 = error. Bits 3:0 are always 0.
- R3: A write (cmd_wr_i high at a clock edge) with cmd_i[7:5] = 6 sets the enable flag, and code 7 clears it. The change is visible in status_o after that edge.
- R4: Code 4 sets the pending flag. Code 5 clears the pending flag and the error flag together.
- R5: Code 2 sets the under-service flag and code 3 clears it. Code 1 clears pending, error and under-service. Code 0 changes nothing.
- R6: event_i high at an edge sets the pending flag. If pending was already set, the error flag is also set. A code 1 or code 5 write at the same edge wins, leaving both pending and error clear.
- R7: irq_o is high exactly when pending and enable are set, under-service is clear, mie_i is high and iei_i is high. irq_o follows the inputs with no register.
- R8: ieo_o is low when iei_i is low, when under-service is set, or when pending, enable and mie_i are all high. Otherwise it is high.
- R9: inta_i high at an edge while irq_o is high sets the under-service flag. inta_i while irq_o is low has no effect.
- R10: In the cycle after an accepted acknowledge with no_vec_i low, vec_valid_o is high for one cycle. vec_o then equals vec_base_i, or, with vis_i high, {vec_base_i[7:4], error, enable, pending, vec_base_i[0]}, where both vec_base_i and the flags are taken from the acknowledge cycle.
- R11: With no_vec_i high, an accepted acknowledge leaves vec_valid_o low. vec_o is 0 whenever vec_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous reset strobe from the master control reset bit |
| cmd_wr_i | input | 1 | Command/status byte write strobe |
| cmd_i | input | 8 | Written byte; bits 7:5 hold the command code |
| event_i | input | 1 | Source event strobe |
| mie_i | input | 1 | Master interrupt enable |
| no_vec_i | input | 1 | Suppress vector on acknowledge |
| vis_i | input | 1 | Vector carries status for this source's group |
| vec_base_i | input | 8 | Group interrupt vector register value |
| iei_i | input | 1 | Daisy-chain enable in |
| inta_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request |
| ieo_o | output | 1 | Daisy-chain enable out to lower priority |
| vec_o | output | 8 | Returned vector |
| vec_valid_o | output | 1 | Vector valid |
| status_o | output | 8 | Flag readback byte |

## Verification
Flag changes from commands, events, acknowledges and soft reset all land at the next clock edge. They are due in status_o one cycle after the stimulus. irq_o and ieo_o have no register: they respond in the same cycle to mie_i and iei_i, and one cycle after any flag change. The vector is registered, so it appears exactly one cycle after the acknowledge and is gone the cycle after that. The bench drives inputs just after the falling edge. It advances a behavioural model at each rising edge and compares every output at the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/irq_cell_pkg.sv
package irq_cell_pkg;
  localparam int BYTE_W  = 8;
  localparam int CODE_HI = 7;
  localparam int CODE_LO = 5;
  localparam int CODE_W  = CODE_HI - CODE_LO + 1;

  typedef enum logic [CODE_W-1:0] {
    OP_NOP       = 3'd0,
    OP_CLR_BOTH  = 3'd1,
    OP_SET_SVC   = 3'd2,
    OP_CLR_SVC   = 3'd3,
    OP_SET_PEND  = 3'd4,
    OP_CLR_PEND  = 3'd5,
    OP_SET_EN    = 3'd6,
    OP_CLR_EN    = 3'd7
  } irq_op_e;

  typedef struct packed {
    logic svc;
    logic en;
    logic pend;
    logic err;
  } irq_flags_t;

  typedef struct packed {
    logic set_pend;
    logic clr_pend;
    logic set_svc;
    logic clr_svc;
    logic set_en;
    logic clr_en;
  } irq_strobe_t;

  function automatic logic [BYTE_W-1:0] f_status(irq_flags_t f);
    return {f.svc, f.en, f.pend, f.err, {(BYTE_W-4){1'b0}}};
  endfunction

  function automatic logic [BYTE_W-1:0] f_vector(logic [BYTE_W-1:0] base,
                                                 logic vis, irq_flags_t f);
    if (vis) return {base[BYTE_W-1:4], f.err, f.en, f.pend, base[0]};
    return base;
  endfunction
endpackage

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec
  import irq_cell_pkg::*;
(
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output irq_strobe_t       stb_o
);
  irq_op_e op;
  assign op = irq_op_e'(byte_i[CODE_HI:CODE_LO]);

  always_comb begin
    stb_o = '0;
    if (wr_i) begin
      case (op)
        OP_CLR_BOTH: begin stb_o.clr_pend = 1'b1; stb_o.clr_svc = 1'b1; end
        OP_SET_SVC:  stb_o.set_svc  = 1'b1;
        OP_CLR_SVC:  stb_o.clr_svc  = 1'b1;
        OP_SET_PEND: stb_o.set_pend = 1'b1;
        OP_CLR_PEND: stb_o.clr_pend = 1'b1;
        OP_SET_EN:   stb_o.set_en   = 1'b1;
        OP_CLR_EN:   stb_o.clr_en   = 1'b1;
        default:     stb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irq_cell_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst_i,
  input  irq_strobe_t stb_i,
  input  logic        event_i,
  input  logic        ack_i,
  output irq_flags_t  flags_o
);
  irq_flags_t nxt;
  logic       overrun;

  assign overrun = event_i & flags_o.pend;

  always_comb begin
    nxt = flags_o;
    if (stb_i.clr_pend) begin
      nxt.pend = 1'b0;
      nxt.err  = 1'b0;
    end else begin
      nxt.pend = flags_o.pend | stb_i.set_pend | event_i;
      nxt.err  = flags_o.err | overrun;
    end
    if (stb_i.clr_svc)      nxt.svc = 1'b0;
    else if (stb_i.set_svc) nxt.svc = 1'b1;
    if (ack_i)              nxt.svc = 1'b1;
    if (stb_i.clr_en)       nxt.en  = 1'b0;
    else if (stb_i.set_en)  nxt.en  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_o <= '0;
    else if (soft_rst_i) flags_o <= '0;
    else                 flags_o <= nxt;
  end
endmodule

// File: rtl/irq_chain.sv
module irq_chain
  import irq_cell_pkg::*;
(
  input  irq_flags_t flags_i,
  input  logic       mie_i,
  input  logic       iei_i,
  output logic       irq_o,
  output logic       ieo_o
);
  logic armed;
  assign armed = flags_i.pend & flags_i.en & mie_i;
  assign irq_o = armed & ~flags_i.svc & iei_i;
  assign ieo_o = iei_i & ~flags_i.svc & ~armed;
endmodule

// File: rtl/irq_vec_out.sv
module irq_vec_out
  import irq_cell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              ack_i,
  input  logic              no_vec_i,
  input  logic              vis_i,
  input  logic [BYTE_W-1:0] base_i,
  input  irq_flags_t        flags_i,
  output logic [BYTE_W-1:0] vec_o,
  output logic              valid_o
);
  logic give;
  assign give = ack_i & ~no_vec_i & ~soft_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else if (give) begin
      vec_o   <= f_vector(base_i, vis_i, flags_i);
      valid_o <= 1'b1;
    end else begin
      vec_o   <= '0;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst_i,
  input  logic       cmd_wr_i,
  input  logic [7:0] cmd_i,
  input  logic       event_i,
  input  logic       mie_i,
  input  logic       no_vec_i,
  input  logic       vis_i,
  input  logic [7:0] vec_base_i,
  input  logic       iei_i,
  input  logic       inta_i,
  output logic       irq_o,
  output logic       ieo_o,
  output logic [7:0] vec_o,
  output logic       vec_valid_o,
  output logic [7:0] status_o
);
  irq_strobe_t stb;
  irq_flags_t  flags;
  logic        ack_ok;

  assign ack_ok   = inta_i & irq_o;
  assign status_o = f_status(flags);

  irq_cmd_dec u_dec (
    .wr_i   (cmd_wr_i),
    .byte_i (cmd_i),
    .stb_o  (stb)
  );

  irq_flag_reg u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .stb_i      (stb),
    .event_i    (event_i),
    .ack_i      (ack_ok),
    .flags_o    (flags)
  );

  irq_chain u_chain (
    .flags_i (flags),
    .mie_i   (mie_i),
    .iei_i   (iei_i),
    .irq_o   (irq_o),
    .ieo_o   (ieo_o)
  );

  irq_vec_out u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst_i),
    .ack_i      (ack_ok),
    .no_vec_i   (no_vec_i),
    .vis_i      (vis_i),
    .base_i     (vec_base_i),
    .flags_i    (flags),
    .vec_o      (vec_o),
    .valid_o    (vec_valid_o)
  );
endmodule

// File: rtl/irq_src_cell_chk.sv
module irq_src_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst_i,
  input logic       cmd_wr_i,
  input logic [7:0] cmd_i,
  input logic       mie_i,
  input logic       no_vec_i,
  input logic       iei_i,
  input logic       inta_i,
  input logic       irq_o,
  input logic       ieo_o,
  input logic [7:0] vec_o,
  input logic       vec_valid_o,
  input logic [7:0] status_o
);
  p_soft_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst_i) |-> (status_o[7:4] == 4'b0 && !vec_valid_o));

  p_low_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3:0] == 4'b0);

  p_set_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr_i && cmd_i[7:5] == 3'd6 && !soft_rst_i) |-> status_o[6]);

  p_clr_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr_i && (cmd_i[7:5] == 3'd5 || cmd_i[7:5] == 3'd1))
      |-> (!status_o[5] && !status_o[4]));

  p_err_with_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[4] |-> status_o[5]);

  p_irq_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[6] && status_o[5] && !status_o[7] && mie_i && iei_i));

  p_svc_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] |-> (!ieo_o && !irq_o));

  p_ack_svc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inta_i && irq_o && !soft_rst_i) |-> status_o[7]);

  p_vec_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(inta_i && irq_o && !no_vec_i));

  p_vec_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> (vec_o == 8'h00));
endmodule

bind irq_src_cell irq_src_cell_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst_i  (soft_rst_i),
  .cmd_wr_i    (cmd_wr_i),
  .cmd_i       (cmd_i),
  .mie_i       (mie_i),
  .no_vec_i    (no_vec_i),
  .iei_i       (iei_i),
  .inta_i      (inta_i),
  .irq_o       (irq_o),
  .ieo_o       (ieo_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .status_o    (status_o)
);

// File: tb/irq_src_cell_tb.sv
module irq_src_cell_tb;
  logic clk = 0, rst_n = 0, soft_rst = 0, cmd_wr = 0, evt = 0, mie = 0;
  logic no_vec = 0, vis = 0, iei = 1, inta = 0;
  logic [7:0] cmd = 0, base = 8'hA0;
  logic irq, ieo, vvalid;
  logic [7:0] vec, stat;
  int tests = 0, fails = 0, cycles = 0;

  // reference model state
  bit m_ip, m_ie, m_ius, m_err, m_vv;
  int m_vec;

  always #10 clk = ~clk;

  irq_src_cell u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .cmd_wr_i(cmd_wr),
    .cmd_i(cmd), .event_i(evt), .mie_i(mie), .no_vec_i(no_vec), .vis_i(vis),
    .vec_base_i(base), .iei_i(iei), .inta_i(inta), .irq_o(irq), .ieo_o(ieo),
    .vec_o(vec), .vec_valid_o(vvalid), .status_o(stat));

  function automatic bit mod_irq();
    return m_ip && m_ie && !m_ius && mie && iei;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ip = 0; m_ie = 0; m_ius = 0; m_err = 0; m_vv = 0; m_vec = 0;
    end else begin
      bit ack, clr_p;
      int code;
      ack  = mod_irq() && inta;
      code = cmd_wr ? int'(cmd[7:5]) : 0;
      if (soft_rst) begin
        m_ip = 0; m_ie = 0; m_ius = 0; m_err = 0; m_vv = 0; m_vec = 0;
      end else begin
        m_vv  = ack && !no_vec;
        m_vec = m_vv ? (vis ? (base & 8'hF1) + 8*m_err + 4*m_ie + 2*m_ip : base) : 0;
        clr_p = (code == 1 || code == 5);
        if (clr_p) begin m_ip = 0; m_err = 0; end
        else begin
          if (evt && m_ip) m_err = 1;
          if (evt || code == 4) m_ip = 1;
        end
        if (code == 1 || code == 3) m_ius = 0;
        if (code == 2) m_ius = 1;
        if (ack) m_ius = 1;
        if (code == 6) m_ie = 1;
        if (code == 7) m_ie = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(stat == {m_ius, m_ie, m_ip, m_err, 4'b0}, "R2 status", stat,
          {m_ius, m_ie, m_ip, m_err, 4'b0});
    check(irq == mod_irq(), "R7 irq", irq, mod_irq());
    check(ieo == (iei && !m_ius && !(m_ip && m_ie && mie)), "R8 ieo", ieo,
          iei && !m_ius && !(m_ip && m_ie && mie));
    check(vvalid == m_vv && vec == m_vec[7:0], "R10 vector", {vvalid, vec},
          {m_vv, m_vec[7:0]});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic wr(input int code);
    cmd_wr = 1; cmd = 8'(code << 5) | 8'h0B; tick(); cmd_wr = 0; cmd = 0;
  endtask
  task automatic pulse_evt(); evt = 1; tick(); evt = 0; endtask
  task automatic ack(); inta = 1; tick(); inta = 0; endtask

  initial begin
    tick(); tick();
    check(stat == 0 && irq == 0 && vvalid == 0, "R1 during reset", stat, 0);
    rst_n = 1; mie = 1; tick();
    check(stat == 8'h00, "R1 after reset", stat, 0);
    wr(6); check(stat == 8'h40, "R3 set enable", stat, 8'h40);
    wr(0); check(stat == 8'h40, "R5 null code no effect", stat, 8'h40);
    wr(4); check(stat == 8'h60 && irq, "R4 set pending raises irq", {irq, stat}, 9'h160);
    check(!ieo, "R8 pending blocks chain", ieo, 0);
    iei = 0; #1; check(!irq && !ieo, "R7 chain input low", {irq, ieo}, 0);
    iei = 1; mie = 0; #1;
    check(!irq && ieo, "R7 R8 master enable off", {irq, ieo}, 1);
    inta = 1; tick(); inta = 0;
    check(stat == 8'h60, "R9 ack ignored when no request", stat, 8'h60);
    mie = 1; tick();
    ack(); check(vvalid && vec == 8'hA0, "R10 plain vector", vec, 8'hA0);
    check(stat == 8'hE0, "R9 ack sets service", stat, 8'hE0);
    tick(); check(!vvalid && vec == 0, "R11 vector idle", vec, 0);
    wr(3); check(stat == 8'h60, "R5 clear service", stat, 8'h60);
    pulse_evt(); check(stat == 8'h70, "R6 overrun error", stat, 8'h70);
    vis = 1; ack();
    check(vvalid && vec == 8'hAE, "R10 status in vector", vec, 8'hAE);
    wr(5); check(stat == 8'hC0, "R4 clear pending and error", stat, 8'hC0);
    wr(1); check(stat == 8'h40, "R5 clear both", stat, 8'h40);
    pulse_evt(); check(stat == 8'h60, "R6 event sets pending", stat, 8'h60);
    evt = 1; cmd_wr = 1; cmd = 8'hA0; tick(); evt = 0; cmd_wr = 0;
    check(stat == 8'h40, "R6 clear wins over event", stat, 8'h40);
    pulse_evt(); no_vec = 1; ack(); no_vec = 0;
    check(!vvalid && vec == 0 && stat[7], "R11 no vector", {vvalid, vec}, 0);
    wr(2); wr(7); check(stat == 8'hA0, "R3 clear enable", stat, 8'hA0);
    soft_rst = 1; tick(); soft_rst = 0;
    check(stat == 0 && !irq && !vvalid, "R1 soft reset", stat, 0);
    for (int i = 0; i < 300; i++) begin
      evt = ($urandom % 5) == 0; inta = ($urandom % 4) == 0;
      cmd_wr = ($urandom % 3) == 0; cmd = 8'($urandom);
      mie = ($urandom % 8) != 0; iei = ($urandom % 8) != 0;
      vis = $urandom % 2; no_vec = ($urandom % 4) == 0;
      soft_rst = ($urandom % 50) == 0; base = 8'($urandom);
      tick();
    end
    evt = 0; inta = 0; cmd_wr = 0; soft_rst = 0; tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule